// File: doc/BRIEF.md
# Display Auxiliary-Channel Transaction Sequencer

This block runs one auxiliary-channel transaction at a time on behalf of a host. On a go strobe it captures a 4-bit command, a 20-bit address, a byte length and up to `MAX_LEN` write bytes. It then writes the request into a byte-wide transmit buffer that belongs to the serializer: three header bytes, an optional length byte, and the payload when the command is a write. After that it raises a one-cycle start pulse to the link layer.

When the link layer signals completion, the block classifies the outcome from the link's error flags and reply byte count, in a fixed priority order. If the reply passes those checks, it reads the receive buffer back through the same index port. The upper nibble of the first returned byte is the reply code. On an acknowledge, the remaining bytes are stored as read data. The result stays on the outputs until the host acknowledges it.

States: `ST_IDLE` (waits for go), `ST_LOAD` (one buffer write per cycle), `ST_LAUNCH` (start pulse), `ST_WAIT` (waits for link done), `ST_READ` (one buffer read per cycle), `ST_DONE` (result held). Transitions:
- IDLE→LOAD on go.
- LOAD→LAUNCH after the last byte is written.
- LAUNCH→WAIT always.
- WAIT→DONE on done with a failing classification.
- WAIT→READ on done with a passing classification.
- READ→DONE after the reply code byte when the code is not ACK, on overflow, or when there are no data bytes. Otherwise READ→DONE after the last data byte.
- DONE→IDLE on acknowledge.

Top module: `aux_txn_seq`

## Requirements
- R1: The first three buffer writes, at indices 0, 1 and 2, carry `{cmd, addr[19:16]}`, `addr[15:8]` and `addr[7:0]`. They start in the cycle after go is accepted and occur on consecutive cycles.
- R2: When the length is nonzero, index 3 carries length minus one. When the length is zero, no fourth header byte is written.
- R3: `tx_count` is 3, or 4 when the length is nonzero, plus the length for write commands. The write commands are 0x0 (I2C write), 0x4 (I2C write, transaction continues) and 0x8 (native write). Only for these commands do the payload bytes follow the header: byte j is `host_wdata[8j+7:8j]`. The number of buffer writes equals `tx_count`.
- R4: The buffer index is 0 at the first access of every load and every readout, and it rises by one per access. The last load write is followed in the next cycle by a single-cycle `link_start`.
- R5: Result codes are 0 success, 1 disconnect, 2 timeout, 3 invalid reply and 4 overflow. The disconnect flag at link done gives result 1, whatever other flags are set.
- R6: Without disconnect, the receive-timeout flag gives result 2, even when invalid-reply flags are also set.
- R7: Any one of invalid stop, no-detect, invalid-high or invalid-low gives result 3. The minimum-count-violation flag has no effect on the result.
- R8: A clean completion with a reply byte count of 0 gives result 3.
- R9: The reply code is bits 7:4 of receive byte 0. For a code of 0 (ACK), `rd_count` is the reply count minus one and `rd_data` byte j equals receive byte j+1. For any other code, the result is 0 and `rd_count` is 0.
- R10: An ACK whose data byte count (reply count minus one) exceeds the requested length gives result 4 and `rd_count` 0.
- R11: `done` stays high until `done_ack`. A go that arrives while the block is busy or done starts nothing. `busy` is high from the cycle after acceptance until `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_go | input | 1 | Start strobe, taken only when idle |
| host_cmd | input | 4 | Request command code |
| host_addr | input | 20 | Request address |
| host_len | input | CNT_W | Byte length, clamped to MAX_LEN |
| host_wdata | input | MAX_LEN*8 | Write payload, byte j at bits 8j+7:8j |
| done_ack | input | 1 | Clears the held result |
| buf_idx | output | CNT_W | Buffer byte index |
| buf_we | output | 1 | Buffer write strobe |
| buf_re | output | 1 | Buffer read strobe |
| buf_wdata | output | 8 | Byte being written |
| buf_rdata | input | 8 | Byte at `buf_idx`, combinational |
| tx_count | output | CNT_W | Bytes to transmit |
| link_start | output | 1 | One-cycle start to the link layer |
| link_done | input | 1 | Link layer finished |
| link_count | input | CNT_W | Reply bytes received |
| rx_discon | input | 1 | Hot-plug disconnect seen |
| rx_timeout | input | 1 | Receive timeout |
| rx_inv_stop | input | 1 | Invalid stop pattern |
| rx_no_det | input | 1 | Reply not detected |
| rx_inv_high | input | 1 | Invalid high symbol |
| rx_inv_low | input | 1 | Invalid low symbol |
| rx_min_viol | input | 1 | Minimum-count violation (debug only) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Result held |
| result | output | 3 | Outcome code |
| reply_code | output | 4 | Reply nibble |
| rd_count | output | CNT_W | Read data bytes returned |
| rd_data | output | MAX_LEN*8 | Read data, byte j at bits 8j+7:8j |

## Verification
The first load write appears one cycle after the edge that accepts go. Each later byte follows one cycle after the previous one, and `link_start` comes one cycle after the last write. The classification is registered on the edge that samples `link_done`, so a failing result and `done` show in the next cycle. A passing reply adds one read cycle for the code byte plus one per data byte. The bench drives on the falling edge and compares every buffer write against its own queue in the cycle it occurs. It then waits for `done` before checking the result fields, and probes go-rejection in the cycle after each stray go.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_LAUNCH, ST_WAIT, ST_READ, ST_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_DISCON   = 3'd1,
        RES_TIMEOUT  = 3'd2,
        RES_INVALID  = 3'd3,
        RES_OVERFLOW = 3'd4
    } seq_result_t;

    localparam logic [3:0] CMD_I2C_WR     = 4'h0;
    localparam logic [3:0] CMD_I2C_WR_MOT = 4'h4;
    localparam logic [3:0] CMD_NAT_WR     = 4'h8;

    typedef struct packed {
        logic discon;
        logic timeout;
        logic inv_stop;
        logic no_det;
        logic inv_high;
        logic inv_low;
        logic min_viol;
    } rx_flags_t;

endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack import aux_seq_pkg::*; #(
    parameter int MAX_LEN = 16,
    parameter int CNT_W   = 5
) (
    input  logic [3:0]           cmd,
    input  logic [19:0]          addr,
    input  logic [CNT_W-1:0]     len,
    input  logic [MAX_LEN*8-1:0] payload,
    input  logic [CNT_W-1:0]     idx,
    output logic [7:0]           byte_out,
    output logic [CNT_W-1:0]     byte_cnt
);
    logic             is_write;
    logic [CNT_W-1:0] hdr_n;
    logic [CNT_W-1:0] pidx;

    always_comb begin
        is_write = (cmd == CMD_I2C_WR) || (cmd == CMD_I2C_WR_MOT) || (cmd == CMD_NAT_WR);
        hdr_n    = (len != '0) ? CNT_W'(4) : CNT_W'(3);
        byte_cnt = hdr_n + (is_write ? len : '0);
        pidx     = idx - hdr_n;
        byte_out = '0;
        if (idx == CNT_W'(0)) begin
            byte_out = {cmd, addr[19:16]};
        end else if (idx == CNT_W'(1)) begin
            byte_out = addr[15:8];
        end else if (idx == CNT_W'(2)) begin
            byte_out = addr[7:0];
        end else if ((idx == CNT_W'(3)) && (len != '0)) begin
            byte_out = 8'(len) - 8'd1;
        end else begin
            for (int j = 0; j < MAX_LEN; j++) begin
                if (pidx == CNT_W'(j)) byte_out = payload[8*j +: 8];
            end
        end
    end

endmodule

// File: rtl/aux_reply_class.sv
module aux_reply_class import aux_seq_pkg::*; #(
    parameter int CNT_W = 5
) (
    input  rx_flags_t        flags,
    input  logic [CNT_W-1:0] reply_cnt,
    output logic             fail,
    output seq_result_t      fail_res
);
    logic unused_min_viol;
    assign unused_min_viol = flags.min_viol;

    always_comb begin
        fail     = 1'b1;
        fail_res = RES_OK;
        if (flags.discon) begin
            fail_res = RES_DISCON;
        end else if (flags.timeout) begin
            fail_res = RES_TIMEOUT;
        end else if (flags.inv_stop || flags.no_det || flags.inv_high || flags.inv_low) begin
            fail_res = RES_INVALID;
        end else if (reply_cnt == '0) begin
            fail_res = RES_INVALID;
        end else begin
            fail = 1'b0;
        end
    end

endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq import aux_seq_pkg::*; #(
    parameter  int MAX_LEN = 16,
    localparam int CNT_W   = $clog2(MAX_LEN + 5)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_go,
    input  logic [3:0]           host_cmd,
    input  logic [19:0]          host_addr,
    input  logic [CNT_W-1:0]     host_len,
    input  logic [MAX_LEN*8-1:0] host_wdata,
    input  logic                 done_ack,
    output logic [CNT_W-1:0]     buf_idx,
    output logic                 buf_we,
    output logic                 buf_re,
    output logic [7:0]           buf_wdata,
    input  logic [7:0]           buf_rdata,
    output logic [CNT_W-1:0]     tx_count,
    output logic                 link_start,
    input  logic                 link_done,
    input  logic [CNT_W-1:0]     link_count,
    input  logic                 rx_discon,
    input  logic                 rx_timeout,
    input  logic                 rx_inv_stop,
    input  logic                 rx_no_det,
    input  logic                 rx_inv_high,
    input  logic                 rx_inv_low,
    input  logic                 rx_min_viol,
    output logic                 busy,
    output logic                 done,
    output logic [2:0]           result,
    output logic [3:0]           reply_code,
    output logic [CNT_W-1:0]     rd_count,
    output logic [MAX_LEN*8-1:0] rd_data
);
    seq_state_t           st_q, st_d;
    logic [CNT_W-1:0]     idx_q, rcnt_q, len_q, rd_cnt_q;
    logic [3:0]           cmd_q, code_q;
    logic [19:0]          addr_q;
    logic [MAX_LEN*8-1:0] wdat_q, rd_q;
    seq_result_t          res_q;

    logic [7:0]           pack_byte;
    logic [CNT_W-1:0]     pack_cnt;
    rx_flags_t            flags;
    logic                 cls_fail;
    seq_result_t          cls_res;
    logic [3:0]           rd_code;
    logic [CNT_W-1:0]     data_cnt;
    logic [CNT_W-1:0]     len_in;

    assign flags    = '{discon: rx_discon, timeout: rx_timeout, inv_stop: rx_inv_stop,
                        no_det: rx_no_det, inv_high: rx_inv_high, inv_low: rx_inv_low,
                        min_viol: rx_min_viol};
    assign rd_code  = buf_rdata[7:4];
    assign data_cnt = rcnt_q - 1'b1;
    assign len_in   = (host_len > CNT_W'(MAX_LEN)) ? CNT_W'(MAX_LEN) : host_len;

    aux_hdr_pack #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_pack (
        .cmd      (cmd_q),
        .addr     (addr_q),
        .len      (len_q),
        .payload  (wdat_q),
        .idx      (idx_q),
        .byte_out (pack_byte),
        .byte_cnt (pack_cnt)
    );

    aux_reply_class #(.CNT_W(CNT_W)) u_class (
        .flags     (flags),
        .reply_cnt (link_count),
        .fail      (cls_fail),
        .fail_res  (cls_res)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (host_go) st_d = ST_LOAD;
            ST_LOAD:   if (idx_q == pack_cnt - 1'b1) st_d = ST_LAUNCH;
            ST_LAUNCH: st_d = ST_WAIT;
            ST_WAIT:   if (link_done) st_d = cls_fail ? ST_DONE : ST_READ;
            ST_READ: begin
                if (idx_q == '0) begin
                    if ((rd_code != 4'h0) || (data_cnt > len_q) || (data_cnt == '0)) st_d = ST_DONE;
                end else if (idx_q == data_cnt) begin
                    st_d = ST_DONE;
                end
            end
            ST_DONE:   if (done_ack) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        buf_we     = 1'b0;
        buf_re     = 1'b0;
        buf_idx    = '0;
        buf_wdata  = '0;
        link_start = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (st_q)
            ST_IDLE:   busy = 1'b0;
            ST_LOAD: begin
                buf_we    = 1'b1;
                buf_idx   = idx_q;
                buf_wdata = pack_byte;
            end
            ST_LAUNCH: link_start = 1'b1;
            ST_WAIT:   ;
            ST_READ: begin
                buf_re  = 1'b1;
                buf_idx = idx_q;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default:   busy = 1'b0;
        endcase
    end

    assign tx_count   = pack_cnt;
    assign result     = res_q;
    assign reply_code = code_q;
    assign rd_count   = rd_cnt_q;
    assign rd_data    = rd_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            rcnt_q   <= '0;
            len_q    <= '0;
            rd_cnt_q <= '0;
            cmd_q    <= '0;
            code_q   <= '0;
            addr_q   <= '0;
            wdat_q   <= '0;
            rd_q     <= '0;
            res_q    <= RES_OK;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (host_go) begin
                        cmd_q    <= host_cmd;
                        addr_q   <= host_addr;
                        len_q    <= len_in;
                        wdat_q   <= host_wdata;
                        idx_q    <= '0;
                        res_q    <= RES_OK;
                        code_q   <= '0;
                        rd_cnt_q <= '0;
                        rd_q     <= '0;
                    end
                end
                ST_LOAD: idx_q <= idx_q + 1'b1;
                ST_WAIT: begin
                    if (link_done) begin
                        rcnt_q <= link_count;
                        idx_q  <= '0;
                        if (cls_fail) res_q <= cls_res;
                    end
                end
                ST_READ: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == '0) begin
                        code_q <= rd_code;
                        if ((rd_code == 4'h0) && (data_cnt > len_q)) res_q <= RES_OVERFLOW;
                    end else begin
                        for (int j = 0; j < MAX_LEN; j++) begin
                            if (idx_q == CNT_W'(j + 1)) rd_q[8*j +: 8] <= buf_rdata;
                        end
                        if (idx_q == data_cnt) rd_cnt_q <= data_cnt;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/aux_txn_seq_chk.sv
module aux_txn_seq_chk #(
    parameter  int MAX_LEN = 16,
    localparam int CNT_W   = $clog2(MAX_LEN + 5)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             buf_we,
    input logic             buf_re,
    input logic [CNT_W-1:0] buf_idx,
    input logic [CNT_W-1:0] tx_count,
    input logic             link_start,
    input logic             link_done,
    input logic [CNT_W-1:0] link_count,
    input logic             rx_discon,
    input logic             rx_timeout,
    input logic             rx_inv_stop,
    input logic             rx_no_det,
    input logic             rx_inv_high,
    input logic             rx_inv_low,
    input logic             done,
    input logic             done_ack,
    input logic [2:0]       result,
    input logic [CNT_W-1:0] rd_count
);
    logic wait_q;
    logic any_inv;
    assign any_inv = rx_inv_stop | rx_no_det | rx_inv_high | rx_inv_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wait_q <= 1'b0;
        else if (link_start) wait_q <= 1'b1;
        else if (link_done)  wait_q <= 1'b0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && buf_re)); // R4
    AST_LOAD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && !$past(buf_we)) |-> (buf_idx == '0)); // R4
    AST_READ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_re && !$past(buf_re)) |-> (buf_idx == '0)); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_we && $past(buf_we)) || (buf_re && $past(buf_re))) |-> (buf_idx == $past(buf_idx) + 1'b1)); // R4
    AST_LAUNCH_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        link_start |-> ($past(buf_we) && ($past(buf_idx) == tx_count - 1'b1))); // R3
    AST_DISCON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && link_done && rx_discon) |=> (done && result == 3'd1)); // R5
    AST_TIMEOUT_OVER_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && link_done && !rx_discon && rx_timeout) |=> (done && result == 3'd2)); // R6
    AST_INVALID_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && link_done && !rx_discon && !rx_timeout && any_inv) |=> (done && result == 3'd3)); // R7
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && link_done && !rx_discon && !rx_timeout && !any_inv && link_count == '0) |=> (done && result == 3'd3)); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ack) |=> (done && $stable(result))); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd4) |-> (rd_count == '0)); // R10

endmodule

bind aux_txn_seq aux_txn_seq_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_we      (buf_we),
    .buf_re      (buf_re),
    .buf_idx     (buf_idx),
    .tx_count    (tx_count),
    .link_start  (link_start),
    .link_done   (link_done),
    .link_count  (link_count),
    .rx_discon   (rx_discon),
    .rx_timeout  (rx_timeout),
    .rx_inv_stop (rx_inv_stop),
    .rx_no_det   (rx_no_det),
    .rx_inv_high (rx_inv_high),
    .rx_inv_low  (rx_inv_low),
    .done        (done),
    .done_ack    (done_ack),
    .result      (result),
    .rd_count    (rd_count)
);

// File: tb/test_aux_txn_seq.sv
module test_aux_txn_seq;
    localparam int MAX_LEN = 16;
    localparam int CNT_W   = $clog2(MAX_LEN + 5);
    localparam int DEPTH   = MAX_LEN + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                 host_go = 0;
    logic [3:0]           host_cmd = 0;
    logic [19:0]          host_addr = 0;
    logic [CNT_W-1:0]     host_len = 0;
    logic [MAX_LEN*8-1:0] host_wdata = 0;
    logic                 done_ack = 0;
    logic [CNT_W-1:0]     buf_idx;
    logic                 buf_we, buf_re;
    logic [7:0]           buf_wdata, buf_rdata;
    logic [CNT_W-1:0]     tx_count;
    logic                 link_start;
    logic                 link_done = 0;
    logic [CNT_W-1:0]     link_count = 0;
    logic [6:0]           flg = 0;
    logic                 busy, done;
    logic [2:0]           result;
    logic [3:0]           reply_code;
    logic [CNT_W-1:0]     rd_count;
    logic [MAX_LEN*8-1:0] rd_data;
    logic [7:0]           rbuf [DEPTH];

    assign buf_rdata = (int'(buf_idx) < DEPTH) ? rbuf[buf_idx] : 8'h00;

    aux_txn_seq #(.MAX_LEN(MAX_LEN)) i_aux_txn_seq (
        .clk(clk), .rst_n(rst_n), .host_go(host_go), .host_cmd(host_cmd),
        .host_addr(host_addr), .host_len(host_len), .host_wdata(host_wdata),
        .done_ack(done_ack), .buf_idx(buf_idx), .buf_we(buf_we), .buf_re(buf_re),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .tx_count(tx_count),
        .link_start(link_start), .link_done(link_done), .link_count(link_count),
        .rx_discon(flg[6]), .rx_timeout(flg[5]), .rx_inv_stop(flg[4]),
        .rx_no_det(flg[3]), .rx_inv_high(flg[2]), .rx_inv_low(flg[1]),
        .rx_min_viol(flg[0]), .busy(busy), .done(done), .result(result),
        .reply_code(reply_code), .rd_count(rd_count), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    int wr_seen = 0;
    int exp_tx = 0;
    bit saw_start = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // reference comparison on every falling edge
    always @(negedge clk) begin : mon
        int e;
        if (rst_n) begin
            if (buf_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected buffer write", int'(buf_wdata), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(int'(buf_wdata) == e, "R1/R2/R3", "load byte", int'(buf_wdata), e);
                    chk(int'(buf_idx) == wr_seen, "R4", "load index", int'(buf_idx), wr_seen);
                    wr_seen++;
                end
            end
            if (link_start) begin
                saw_start = 1'b1;
                chk(exp_q.size() == 0, "R3", "bytes left at start", exp_q.size(), 0);
                chk(int'(tx_count) == exp_tx, "R2/R3", "tx_count", int'(tx_count), exp_tx);
            end
        end
    end

    task automatic run(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                       input int rcnt, input logic [7:0] r0, input logic [6:0] f, input bit poke);
        bit is_wr;
        int exp_res, exp_code, exp_rd;
        string tag;
        logic [7:0] pay [MAX_LEN];
        for (int j = 0; j < MAX_LEN; j++) begin
            pay[j] = 8'(int'(addr) + 17 * j + 3);
            host_wdata[8*j +: 8] = pay[j];
        end
        rbuf[0] = r0;
        for (int k = 1; k < DEPTH; k++) rbuf[k] = 8'(k * 29 + int'(addr[7:0]));
        is_wr = (cmd == 4'h0) || (cmd == 4'h4) || (cmd == 4'h8);
        exp_q.delete();
        exp_q.push_back(int'({cmd, addr[19:16]}));
        exp_q.push_back(int'(addr[15:8]));
        exp_q.push_back(int'(addr[7:0]));
        if (len > 0) exp_q.push_back(len - 1);
        if (is_wr) for (int j = 0; j < len; j++) exp_q.push_back(int'(pay[j]));
        exp_tx = ((len > 0) ? 4 : 3) + (is_wr ? len : 0);
        wr_seen = 0;
        saw_start = 1'b0;
        host_cmd = cmd; host_addr = addr; host_len = CNT_W'(len);
        host_go = 1'b1;
        @(negedge clk);
        host_go = 1'b0;
        chk(busy == 1'b1, "R11", "busy after go", int'(busy), 1);
        while (!saw_start) @(negedge clk);
        @(negedge clk);
        if (poke) begin
            host_go = 1'b1; host_cmd = 4'h8; host_len = CNT_W'(5);
            @(negedge clk);
            host_go = 1'b0;
        end
        flg = f; link_count = CNT_W'(rcnt); link_done = 1'b1;
        @(negedge clk);
        link_done = 1'b0; flg = '0;
        while (!done) @(negedge clk);
        exp_code = 0; exp_rd = 0;
        if (f[6])                  begin exp_res = 1; tag = "R5"; end
        else if (f[5])             begin exp_res = 2; tag = "R6"; end
        else if (|f[4:1])          begin exp_res = 3; tag = "R7"; end
        else if (rcnt == 0)        begin exp_res = 3; tag = "R8"; end
        else if (r0[7:4] != 4'h0)  begin exp_res = 0; exp_code = int'(r0[7:4]); tag = "R9"; end
        else if (rcnt - 1 > len)   begin exp_res = 4; tag = "R10"; end
        else                       begin exp_res = 0; exp_rd = rcnt - 1; tag = "R9"; end
        chk(int'(result) == exp_res, tag, "result", int'(result), exp_res);
        chk(int'(reply_code) == exp_code, tag, "reply code", int'(reply_code), exp_code);
        chk(int'(rd_count) == exp_rd, tag, "rd_count", int'(rd_count), exp_rd);
        for (int j = 0; j < exp_rd; j++)
            chk(rd_data[8*j +: 8] == rbuf[j+1], "R9", "read byte", int'(rd_data[8*j +: 8]), int'(rbuf[j+1]));
        // go while done must be ignored
        host_go = 1'b1;
        @(negedge clk);
        host_go = 1'b0;
        chk(done == 1'b1, "R11", "done held", int'(done), 1);
        chk(busy == 1'b0, "R11", "busy while done", int'(busy), 0);
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        chk(done == 1'b0 && busy == 1'b0, "R11", "idle after ack", int'({done, busy}), 0);
        @(negedge clk);
        chk(busy == 1'b0, "R11", "go during done started nothing", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < DEPTH; k++) rbuf[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R11", "reset idle", int'({busy, done}), 0);
        chk(buf_we == 0 && buf_re == 0 && link_start == 0, "R4", "reset strobes", int'({buf_we, buf_re, link_start}), 0);
        chk(result == 0 && rd_count == 0, "R5", "reset result", int'(result), 0);
        chk(int'(tx_count) == 3, "R3", "reset tx_count", int'(tx_count), 3);

        run(4'h8, 20'h5A3C1, 3, 1, 8'h00, 7'b0000000, 0);   // R1 R3 native write
        run(4'h9, 20'hABCDE, 4, 5, 8'h00, 7'b0000000, 0);   // R9 read, count = len+1
        run(4'h1, 20'h00050, 0, 1, 8'h00, 7'b0000000, 0);   // R2 zero length
        run(4'h4, 20'hFFFFF, 16, 1, 8'h00, 7'b0000000, 0);  // R3 full payload
        run(4'h2, 20'h12345, 2, 1, 8'h00, 7'b0000000, 0);   // R3 non-write, no payload
        run(4'h9, 20'h31415, 4, 5, 8'h00, 7'b1111110, 0);   // R5
        run(4'h9, 20'h27182, 4, 5, 8'h00, 7'b0110000, 0);   // R6
        run(4'h9, 20'h00001, 4, 5, 8'h00, 7'b0010000, 0);   // R7 stop
        run(4'h9, 20'h00002, 4, 5, 8'h00, 7'b0001000, 0);   // R7 no-detect
        run(4'h9, 20'h00003, 4, 5, 8'h00, 7'b0000100, 0);   // R7 high
        run(4'h9, 20'h00004, 4, 5, 8'h00, 7'b0000010, 0);   // R7 low
        run(4'h9, 20'h00005, 2, 3, 8'h00, 7'b0000001, 0);   // R7 min-count ignored
        run(4'h9, 20'h00006, 2, 0, 8'h00, 7'b0000000, 0);   // R8
        run(4'h9, 20'h00007, 4, 3, 8'h20, 7'b0000000, 0);   // R9 non-ACK
        run(4'h5, 20'h00008, 2, 5, 8'h00, 7'b0000000, 0);   // R10 overflow
        run(4'h9, 20'h00009, 3, 4, 8'h00, 7'b0000000, 1);   // R11 go while busy

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule